// File: doc/BRIEF.md
# Horizontal Clock Widening During Blanking

This block produces the horizontal transfer clocks of an image sensor as a set of complementary phase pairs. The default build has four pairs, which make eight phases. The block runs from an edge clock at twice the pixel rate. Toggling the phase on every edge-clock tick therefore gives a clock at the pixel frequency.

While the blanking-area flag is high, the clocks can be slowed down to widen each pulse. A 4-bit width code `n` selects the slowdown. A code of zero keeps the pixel rate. A code from 1 to 15 divides the frequency by `2n`, so the slowest setting is 1/30. Widening is allowed only in blanking modes 0 and 1. In mode 2 the code has no effect. The pulse count restarts when widening begins, so the first wide pulse lines up with the start of blanking. When the flag drops, pixel-rate toggling resumes on the next tick.

The controller is a two-state machine:
- `ST_PIXEL` toggles the phase on every tick.
- `ST_WIDE` toggles the phase only when the divider reaches its terminal count.

The machine has two transitions:
- `T_ENTER` goes from `ST_PIXEL` to `ST_WIDE` when the flag is high, the mode permits widening and the code is non-zero.
- `T_LEAVE` goes from `ST_WIDE` to `ST_PIXEL` when any of these three conditions stops holding.

Both transitions toggle the phase and clear the divider.

Top module: `hclk_blank_slowdown`

## Requirements
- R1: While reset is high and on the first sample after it, every positive phase `h_pos` is 0 and every negative phase `h_neg` is 1.
- R2: With `blank_area` sampled low, the positive phase toggles on every tick of `clk_edge`.
- R3: With `blank_area` high and `width_code` equal to 0, the phase toggles on every tick.
- R4: With `blank_area` high, mode 0 and a `width_code` n in 1..15, the phase toggles on the first tick where widening is sampled active. After that it toggles once every 2n ticks. Code 1 therefore holds each level for 2 ticks.
- R5: Code 15 holds each level for exactly 30 ticks.
- R6: Mode 1 (`blank_mode` = 1) widens exactly as mode 0 does.
- R7: With `blank_mode` at 2 (or the unused value 3), the phase toggles on every tick whatever the code.
- R8: On the first tick where `blank_area` is sampled low after widening, the phase toggles. A later blanking interval restarts the wide-pulse alignment from its own first tick.
- R9: Every `h_neg` bit is always the inverse of the matching `h_pos` bit.
- R10: All pairs carry the same waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_edge | input | 1 | Edge clock, twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| blank_area | input | 1 | High inside the blanking window |
| blank_mode | input | 2 | Blanking mode: 0 and 1 allow widening, 2 and 3 do not |
| width_code | input | 4 | 0 = no widening; n = divide by 2n |
| h_pos | output | NUM_PAIRS | Positive phase of each pair |
| h_neg | output | NUM_PAIRS | Negative phase of each pair |

## Verification
The bench targets the tick where blanking starts. A design that fails to restart its divider there would shift the first wide pulse, or make it too short. It measures hold lengths at code 1, a middle code and code 15. An off-by-one in the terminal count would show up as holds of 2n±1 ticks. It also leaves blanking partway through a count and then re-enters. A design that kept stale divider state, or waited for the count to finish, would toggle late. Finally, it runs mode 2 and code 0 inside blanking, where any widening at all is an error.

// File: rtl/hclk_pkg.sv
package hclk_pkg;
    localparam int MODE_W = 2;

    typedef enum logic {
        ST_PIXEL = 1'b0,
        ST_WIDE  = 1'b1
    } hclk_state_e;

    localparam logic [MODE_W-1:0] MODE_NO_WIDEN = 2'd2;
endpackage

// File: rtl/hclk_div_counter.sv
module hclk_div_counter #(
    parameter int CODE_W = 4,
    localparam int CNT_W = CODE_W + 1
) (
    input  logic              clk_edge,
    input  logic              rst,
    input  logic              cnt_clr,
    input  logic [CODE_W-1:0] width_code,
    output logic              term
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   limit;

    // hold length in ticks is twice the code
    assign limit = {1'b0, width_code, 1'b0};
    assign term  = ({1'b0, cnt} + 1'b1) >= limit;

    always_ff @(posedge clk_edge) begin
        if (rst || cnt_clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hclk_mode_fsm.sv
module hclk_mode_fsm
    import hclk_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk_edge,
    input  logic              rst,
    input  logic              blank_area,
    input  logic [MODE_W-1:0] blank_mode,
    input  logic [CODE_W-1:0] width_code,
    input  logic              term,
    output logic              toggle,
    output logic              cnt_clr
);
    hclk_state_e state, state_nxt;
    logic        widen_req;

    assign widen_req = blank_area && (blank_mode < MODE_NO_WIDEN) && (width_code != '0);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_PIXEL: if (widen_req)  state_nxt = ST_WIDE;   // T_ENTER
            ST_WIDE:  if (!widen_req) state_nxt = ST_PIXEL;  // T_LEAVE
            default:  state_nxt = ST_PIXEL;
        endcase
    end

    always_ff @(posedge clk_edge) begin
        if (rst) begin
            state <= ST_PIXEL;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        toggle  = 1'b1;
        cnt_clr = 1'b1;
        unique case (state)
            ST_PIXEL: begin
                toggle  = 1'b1;
                cnt_clr = 1'b1;
            end
            ST_WIDE: begin
                toggle  = (state_nxt == ST_PIXEL) || term;
                cnt_clr = (state_nxt == ST_PIXEL) || term;
            end
            default: begin
                toggle  = 1'b1;
                cnt_clr = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/hclk_phase_drive.sv
module hclk_phase_drive #(
    parameter int NUM_PAIRS = 4
) (
    input  logic                 clk_edge,
    input  logic                 rst,
    input  logic                 toggle,
    output logic [NUM_PAIRS-1:0] h_pos,
    output logic [NUM_PAIRS-1:0] h_neg
);
    logic phase;

    always_ff @(posedge clk_edge) begin
        if (rst) begin
            phase <= 1'b0;
        end else if (toggle) begin
            phase <= ~phase;
        end
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign h_pos[p] = phase;
        assign h_neg[p] = ~phase;
    end
endmodule

// File: rtl/hclk_blank_slowdown.sv
module hclk_blank_slowdown
    import hclk_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int CODE_W    = 4
) (
    input  logic                 clk_edge,
    input  logic                 rst,
    input  logic                 blank_area,
    input  logic [MODE_W-1:0]    blank_mode,
    input  logic [CODE_W-1:0]    width_code,
    output logic [NUM_PAIRS-1:0] h_pos,
    output logic [NUM_PAIRS-1:0] h_neg
);
    logic term;
    logic toggle;
    logic cnt_clr;

    hclk_mode_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk_edge   (clk_edge),
        .rst        (rst),
        .blank_area (blank_area),
        .blank_mode (blank_mode),
        .width_code (width_code),
        .term       (term),
        .toggle     (toggle),
        .cnt_clr    (cnt_clr)
    );

    hclk_div_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk_edge   (clk_edge),
        .rst        (rst),
        .cnt_clr    (cnt_clr),
        .width_code (width_code),
        .term       (term)
    );

    hclk_phase_drive #(.NUM_PAIRS(NUM_PAIRS)) u_drv (
        .clk_edge (clk_edge),
        .rst      (rst),
        .toggle   (toggle),
        .h_pos    (h_pos),
        .h_neg    (h_neg)
    );
endmodule

// File: rtl/hclk_blank_slowdown_chk.sv
module hclk_blank_slowdown_chk #(
    parameter int NUM_PAIRS = 4,
    parameter int CODE_W    = 4
) (
    input logic                 clk_edge,
    input logic                 rst,
    input logic                 blank_area,
    input logic [1:0]           blank_mode,
    input logic [CODE_W-1:0]    width_code,
    input logic [NUM_PAIRS-1:0] h_pos,
    input logic [NUM_PAIRS-1:0] h_neg
);
    a_r1_reset_levels: assert property (@(posedge clk_edge)
        rst |=> (h_pos == '0 && h_neg == '1));

    a_r2_pixel_rate: assert property (@(posedge clk_edge) disable iff (rst)
        !blank_area |=> (h_pos[0] != $past(h_pos[0])));

    a_r3_code_zero: assert property (@(posedge clk_edge) disable iff (rst)
        (blank_area && width_code == '0) |=> (h_pos[0] != $past(h_pos[0])));

    a_r7_mode_two: assert property (@(posedge clk_edge) disable iff (rst)
        (blank_area && blank_mode >= 2'd2) |=> (h_pos[0] != $past(h_pos[0])));

    a_r9_inverted: assert property (@(posedge clk_edge) disable iff (rst)
        (h_neg == ~h_pos));

    a_r10_pairs_match: assert property (@(posedge clk_edge) disable iff (rst)
        (h_pos == '0 || h_pos == '1));
endmodule

bind hclk_blank_slowdown hclk_blank_slowdown_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .CODE_W    (CODE_W)
) u_chk (
    .clk_edge   (clk_edge),
    .rst        (rst),
    .blank_area (blank_area),
    .blank_mode (blank_mode),
    .width_code (width_code),
    .h_pos      (h_pos),
    .h_neg      (h_neg)
);

// File: tb/hclk_blank_slowdown_bench.sv
module hclk_blank_slowdown_bench;
    localparam int NP = 4;

    logic          clk_edge = 1'b0;
    logic          rst = 1'b1;
    logic          blank_area = 1'b0;
    logic [1:0]    blank_mode = 2'd0;
    logic [3:0]    width_code = 4'd0;
    logic [NP-1:0] h_pos;
    logic [NP-1:0] h_neg;

    int  n_checks = 0;
    int  n_errors = 0;
    logic exp_ph = 1'b0;

    always #2 clk_edge = ~clk_edge;

    hclk_blank_slowdown #(.NUM_PAIRS(NP), .CODE_W(4)) u_hclk_blank_slowdown (
        .clk_edge   (clk_edge),
        .rst        (rst),
        .blank_area (blank_area),
        .blank_mode (blank_mode),
        .width_code (width_code),
        .h_pos      (h_pos),
        .h_neg      (h_neg)
    );

    task automatic check_levels(input string tag);
        logic [NP-1:0] ep;
        ep = {NP{exp_ph}};
        n_checks++;
        if (h_pos !== ep) begin
            n_errors++;
            $display("FAIL %s h_pos actual=%b expected=%b", tag, h_pos, ep);
        end
        n_checks++;
        if (h_neg !== ~h_pos) begin
            n_errors++;
            $display("FAIL R9 h_neg actual=%b expected=%b", h_neg, ~h_pos);
        end
    endtask

    // one tick: drive at negedge, let the edge act, sample at next negedge
    task automatic step(input logic b, input logic [1:0] m, input logic [3:0] c,
                        input logic tog, input string tag);
        blank_area = b;
        blank_mode = m;
        width_code = c;
        @(posedge clk_edge);
        @(negedge clk_edge);
        exp_ph = exp_ph ^ tog;
        check_levels(tag);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk_edge);
        exp_ph = 1'b0;
        check_levels("R1");
        rst = 1'b0;
    endtask

    task automatic t_pixel_rate;
        for (int k = 0; k < 8; k++) step(1'b0, 2'd0, 4'd7, 1'b1, "R2");
    endtask

    task automatic t_code_zero;
        for (int k = 0; k < 8; k++) step(1'b1, 2'd0, 4'd0, 1'b1, "R3");
        step(1'b0, 2'd0, 4'd0, 1'b1, "R2");
    endtask

    // widen for len ticks, then leave blanking
    task automatic t_widen(input logic [1:0] m, input logic [3:0] c, input int len,
                           input string tag);
        for (int k = 0; k < len; k++)
            step(1'b1, m, c, (k % (2 * int'(c))) == 0, tag);
        step(1'b0, m, c, 1'b1, "R8");
        step(1'b0, m, c, 1'b1, "R8");
    endtask

    task automatic t_mode_two;
        for (int k = 0; k < 10; k++) step(1'b1, 2'd2, 4'd5, 1'b1, "R7");
        for (int k = 0; k < 4; k++)  step(1'b1, 2'd3, 4'd1, 1'b1, "R7");
        step(1'b0, 2'd2, 4'd5, 1'b1, "R2");
    endtask

    task automatic t_reenter;
        // leave mid-count, then re-enter: alignment restarts
        t_widen(2'd0, 4'd4, 5, "R8");
        t_widen(2'd0, 4'd4, 17, "R8");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk_edge);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk_edge);
        t_reset;
        t_pixel_rate;
        t_code_zero;
        t_widen(2'd0, 4'd1, 8, "R4");
        t_widen(2'd0, 4'd3, 20, "R4");
        t_widen(2'd0, 4'd15, 92, "R5");
        t_widen(2'd1, 4'd2, 13, "R6");
        t_mode_two;
        t_reenter;
        t_widen(2'd1, 4'd1, 6, "R10");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule